// File: doc/BRIEF.md
# Byte-per-clock instruction fetch sequencer

This block paces instruction fetch and completion for a small 8-bit controller core whose code memory delivers one byte per clock. It owns the program counter and the code-memory read strobe. It latches the opcode and up to two operand bytes and raises a one-clock completion pulse at the end of every instruction. Fetch and completion overlap: the clock in which an instruction finishes is also the clock in which the next opcode is read, so a stream of one-byte instructions retires one per clock.

A combinational decoder outside the block looks at `code_data` and supplies the instruction length (1 to 3 bytes) and a timing class. The block samples these on the clock that captures the opcode. In fast timing the clock count follows the byte count, plus fixed extra clocks for branches, the pointer increment, external data moves and the explicit multi-cycle class. The block does not perform external data moves. It only stalls for them and flags the stall. A legacy mode replaces all of this with whole machine cycles of 12 clocks. A separate input stretches every code fetch to three clocks when code sits in slow external memory.

Top module: `byte_fetch_seq`

## Requirements
- R1: While `rst` is high, and in the clock right after it falls, `code_addr` is 0, `code_rd` is 1, `instr_done` is 0 and `instr_cycles` is 0. The first opcode is read from address 0 in that clock.
- R2: In fast mode with internal code, `code_rd` reads one byte every fetch clock and the address steps by one after each byte. A plain instruction of L bytes takes L clocks. Its opcode appears on `opcode`, its second byte on `operand1` and its third byte on `operand2`.
- R3: `instr_done` is high for exactly the last clock of each instruction. In that same clock `code_rd` is high and `code_addr` holds the next opcode's address. No pulse follows the very first opcode read after reset.
- R4: A branch takes its length plus one clock. In the extra clock the byte past the instruction is read and dropped. The address is then loaded from `branch_target`, and the next opcode is read there.
- R5: The pointer-increment class (1 byte) takes 2 clocks. The multi-cycle class takes its length plus its extra count, which ranges from 0 to 7.
- R6: An external data move (1 byte) takes 4 clocks. In the 3 clocks after the opcode read, `xdata_busy` is 1, `code_rd` is 0 and the address holds. `xdata_busy` is 0 in every other clock.
- R7: In fast mode with `ext_code` set, every code byte read holds address and strobe for 3 clocks. The instruction takes 3·L plus its extra clocks.
- R8: With `compat_mode` set, an instruction takes 12 clocks per machine cycle. The counts are: plain, 1 cycle (2 if 3 bytes); branch, pointer increment and external move, 2 cycles; multi-cycle, 1 plus its extra count. Byte reads take one clock each, and `ext_code` has no effect.
- R9: While `instr_done` is high, `instr_cycles` equals the number of clocks since the previous `instr_done`.
- R10: Class codes are 0 plain, 1 branch, 2 pointer increment, 3 external move and 4 multi-cycle. Codes 5 to 7 behave as plain. A length of 0 behaves as 1. Decode inputs are used only in the opcode capture clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| compat_mode | input | 1 | 1 selects legacy 12-clock machine-cycle timing |
| ext_code | input | 1 | 1 marks code as external: each fast-mode fetch takes 3 clocks |
| code_addr | output | ADDR_W | Program counter / code-memory address |
| code_rd | output | 1 | Code-memory read strobe |
| code_data | input | DATA_W | Byte returned by code memory |
| dec_len | input | 2 | Decoded instruction length |
| dec_class | input | 3 | Decoded timing class |
| dec_extra | input | 3 | Extra clocks for the multi-cycle class |
| branch_target | input | ADDR_W | Branch destination, taken in the last extra clock |
| opcode | output | DATA_W | Captured opcode byte |
| operand1 | output | DATA_W | Captured second byte |
| operand2 | output | DATA_W | Captured third byte |
| instr_done | output | 1 | One-clock pulse on the last clock of an instruction |
| instr_cycles | output | CNT_W | Clocks taken by the instruction finishing now |
| xdata_busy | output | 1 | Stall for an external data move |

## Verification
The bench aims at the clocks where one instruction hands over to the next. A design that raised the pulse one clock late, or re-read the opcode, would report every count one too high. A design that forgot to drop the fall-through byte of a branch would fetch its next opcode from the wrong address. A design that kept reading code during a data-move stall would show extra reads. A design that used the three-clock external fetch in legacy mode would report legacy counts that are not multiples of 12. Directed opcodes cover the zero extra count, the extra count of 7, the reserved class codes and the zero length. Randomly built programs cover these again, with branch gaps filled with junk bytes.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [2:0] {
        CLS_PLAIN  = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_PTRINC = 3'd2,
        CLS_XMOVE  = 3'd3,
        CLS_MULTI  = 3'd4
    } iclass_e;

    typedef enum logic [1:0] {
        PH_OPC = 2'd0,
        PH_OPR = 2'd1,
        PH_PAD = 2'd2
    } phase_e;

    typedef struct packed {
        logic [1:0] len;
        iclass_e    cls;
    } instr_info_t;

    function automatic iclass_e norm_class(input logic [2:0] raw);
        if (raw > 3'd4) return CLS_PLAIN;
        return iclass_e'(raw);
    endfunction

    function automatic logic [1:0] norm_len(input logic [1:0] raw);
        return (raw == 2'd0) ? 2'd1 : raw;
    endfunction

    function automatic logic [3:0] extra_clks(input iclass_e c, input logic [2:0] x);
        case (c)
            CLS_BRANCH, CLS_PTRINC: return 4'd1;
            CLS_XMOVE:              return 4'd3;
            CLS_MULTI:              return {1'b0, x};
            default:                return 4'd0;
        endcase
    endfunction

    function automatic logic [3:0] legacy_mc(input logic [1:0] len, input iclass_e c,
                                             input logic [2:0] x);
        case (c)
            CLS_PLAIN:                         return (len == 2'd3) ? 4'd2 : 4'd1;
            CLS_BRANCH, CLS_PTRINC, CLS_XMOVE: return 4'd2;
            CLS_MULTI:                         return {1'b0, x} + 4'd1;
            default:                           return 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/bfs_plan.sv
module bfs_plan
    import bfs_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int EXT_WAIT   = 3,
    parameter int LEGACY_CLK = 12,
    parameter int WAIT_W     = 2
) (
    input  logic              compat_mode,
    input  logic              ext_code,
    input  logic [1:0]        raw_len,
    input  logic [2:0]        raw_class,
    input  logic [2:0]        raw_extra,
    output logic [WAIT_W-1:0] fetch_clks,
    output instr_info_t       info,
    output logic [CNT_W-1:0]  pad_clks
);

    int unsigned legacy_total;

    always_comb begin
        info.len = norm_len(raw_len);
        info.cls = norm_class(raw_class);

        if (!compat_mode && ext_code) fetch_clks = WAIT_W'(EXT_WAIT);
        else                          fetch_clks = WAIT_W'(1);

        legacy_total = LEGACY_CLK * 32'(legacy_mc(info.len, info.cls, raw_extra));
        if (compat_mode) pad_clks = CNT_W'(legacy_total - 32'(info.len));
        else             pad_clks = CNT_W'(extra_clks(info.cls, raw_extra));
    end

endmodule

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
    import bfs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAIT_W-1:0] fetch_clks,
    input  instr_info_t       info,
    input  logic [CNT_W-1:0]  pad_clks,
    input  logic [ADDR_W-1:0] branch_target,
    output logic [ADDR_W-1:0] code_addr,
    output logic              code_rd,
    output logic              instr_done,
    output logic              cap_en,
    output logic [1:0]        cap_idx,
    output logic              xdata_busy,
    output logic              tgt_load,
    output logic              discard
);

    localparam logic [WAIT_W-1:0] WAIT_ONE = 1;
    localparam logic [CNT_W-1:0]  PAD_ONE  = 1;
    localparam logic [ADDR_W-1:0] PC_STEP  = 1;

    phase_e            phase;
    logic [WAIT_W-1:0] sub;
    logic [1:0]        idx;
    logic [CNT_W-1:0]  pad_cnt;
    logic [CNT_W-1:0]  cur_pad;
    logic [1:0]        cur_len;
    iclass_e           cur_cls;
    logic              first;
    logic [ADDR_W-1:0] pc;

    logic fetch_last;
    logic in_fetch;
    logic pad_last;

    always_comb begin
        in_fetch   = (phase == PH_OPC) || (phase == PH_OPR);
        fetch_last = (sub == (fetch_clks - WAIT_ONE));
        pad_last   = (phase == PH_PAD) && (pad_cnt == (cur_pad - PAD_ONE));
        discard    = (phase == PH_PAD) && (cur_cls == CLS_BRANCH) && (pad_cnt == '0);
        tgt_load   = pad_last && (cur_cls == CLS_BRANCH);
        xdata_busy = (phase == PH_PAD) && (cur_cls == CLS_XMOVE);
        code_rd    = in_fetch || discard;
        code_addr  = pc;
        cap_en     = in_fetch && fetch_last;
        cap_idx    = (phase == PH_OPC) ? 2'd0 : idx;
        instr_done = (phase == PH_OPC) && fetch_last && !first;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_OPC;
            sub     <= '0;
            idx     <= 2'd1;
            pad_cnt <= '0;
            cur_pad <= '0;
            cur_len <= 2'd1;
            cur_cls <= CLS_PLAIN;
            first   <= 1'b1;
            pc      <= '0;
        end else begin
            case (phase)
                PH_OPC: begin
                    if (fetch_last) begin
                        sub     <= '0;
                        pc      <= pc + PC_STEP;
                        first   <= 1'b0;
                        cur_len <= info.len;
                        cur_cls <= info.cls;
                        cur_pad <= pad_clks;
                        idx     <= 2'd1;
                        pad_cnt <= '0;
                        if (info.len > 2'd1)      phase <= PH_OPR;
                        else if (pad_clks != '0)  phase <= PH_PAD;
                        else                      phase <= PH_OPC;
                    end else begin
                        sub <= sub + WAIT_ONE;
                    end
                end
                PH_OPR: begin
                    if (fetch_last) begin
                        sub <= '0;
                        pc  <= pc + PC_STEP;
                        if (idx == (cur_len - 2'd1)) begin
                            phase <= (cur_pad != '0) ? PH_PAD : PH_OPC;
                        end else begin
                            idx <= idx + 2'd1;
                        end
                    end else begin
                        sub <= sub + WAIT_ONE;
                    end
                end
                PH_PAD: begin
                    if (pad_last) begin
                        phase   <= PH_OPC;
                        pad_cnt <= '0;
                        if (cur_cls == CLS_BRANCH) pc <= branch_target;
                    end else begin
                        pad_cnt <= pad_cnt + PAD_ONE;
                    end
                end
                default: phase <= PH_OPC;
            endcase
        end
    end

endmodule

// File: rtl/bfs_capture.sv
module bfs_capture #(
    parameter int DATA_W = 8,
    parameter int NBYTES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [1:0]        cap_idx,
    input  logic [DATA_W-1:0] byte_in,
    output logic [DATA_W-1:0] bytes_q [NBYTES]
);

    for (genvar i = 0; i < NBYTES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                 bytes_q[i] <= '0;
            else if (cap_en && (cap_idx == 2'(i)))   bytes_q[i] <= byte_in;
        end
    end

endmodule

// File: rtl/bfs_cycles.sv
module bfs_cycles #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    always_ff @(posedge clk) begin
        if (rst)                count <= '0;
        else if (restart)       count <= CNT_ONE;
        else if (count != '1)   count <= count + CNT_ONE;
    end

endmodule

// File: rtl/byte_fetch_seq.sv
module byte_fetch_seq
    import bfs_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 8,
    parameter int EXT_WAIT   = 3,
    parameter int LEGACY_CLK = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              compat_mode,
    input  logic              ext_code,
    output logic [ADDR_W-1:0] code_addr,
    output logic              code_rd,
    input  logic [DATA_W-1:0] code_data,
    input  logic [1:0]        dec_len,
    input  logic [2:0]        dec_class,
    input  logic [2:0]        dec_extra,
    input  logic [ADDR_W-1:0] branch_target,
    output logic [DATA_W-1:0] opcode,
    output logic [DATA_W-1:0] operand1,
    output logic [DATA_W-1:0] operand2,
    output logic              instr_done,
    output logic [CNT_W-1:0]  instr_cycles,
    output logic              xdata_busy
);

    localparam int WAIT_W = $clog2(EXT_WAIT + 1);
    localparam int NBYTES = 3;

    logic [WAIT_W-1:0] fetch_clks;
    instr_info_t       info;
    logic [CNT_W-1:0]  pad_clks;
    logic              cap_en;
    logic [1:0]        cap_idx;
    logic              tgt_load;
    logic              discard;
    logic [DATA_W-1:0] bytes_q [NBYTES];

    bfs_plan #(
        .CNT_W(CNT_W), .EXT_WAIT(EXT_WAIT), .LEGACY_CLK(LEGACY_CLK), .WAIT_W(WAIT_W)
    ) u_plan (
        .compat_mode (compat_mode),
        .ext_code    (ext_code),
        .raw_len     (dec_len),
        .raw_class   (dec_class),
        .raw_extra   (dec_extra),
        .fetch_clks  (fetch_clks),
        .info        (info),
        .pad_clks    (pad_clks)
    );

    bfs_ctrl #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .fetch_clks    (fetch_clks),
        .info          (info),
        .pad_clks      (pad_clks),
        .branch_target (branch_target),
        .code_addr     (code_addr),
        .code_rd       (code_rd),
        .instr_done    (instr_done),
        .cap_en        (cap_en),
        .cap_idx       (cap_idx),
        .xdata_busy    (xdata_busy),
        .tgt_load      (tgt_load),
        .discard       (discard)
    );

    bfs_capture #(
        .DATA_W(DATA_W), .NBYTES(NBYTES)
    ) u_capture (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .byte_in (code_data),
        .bytes_q (bytes_q)
    );

    bfs_cycles #(
        .CNT_W(CNT_W)
    ) u_cycles (
        .clk     (clk),
        .rst     (rst),
        .restart (cap_en && (cap_idx == 2'd0)),
        .count   (instr_cycles)
    );

    assign opcode   = bytes_q[0];
    assign operand1 = bytes_q[1];
    assign operand2 = bytes_q[2];

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              compat_mode,
    input logic              ext_code,
    input logic [ADDR_W-1:0] code_addr,
    input logic              code_rd,
    input logic [ADDR_W-1:0] branch_target,
    input logic              instr_done,
    input logic [CNT_W-1:0]  instr_cycles,
    input logic              xdata_busy,
    input logic              tgt_load,
    input logic              discard
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (code_addr == '0 && code_rd && !instr_done));

    p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(code_rd) && !$past(compat_mode) && !$past(ext_code)
         && !$past(tgt_load) && !$past(discard))
        |-> code_addr == ADDR_W'($past(code_addr) + 1'b1));

    p_done_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        instr_done |-> code_rd);

    p_branch_redirect_r4: assert property (@(posedge clk) disable iff (rst)
        $past(tgt_load) |-> code_addr == $past(branch_target));

    p_busy_stall_r6: assert property (@(posedge clk) disable iff (rst)
        xdata_busy |-> (!code_rd && !instr_done));

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $past(xdata_busy) |-> code_addr == $past(code_addr));

    p_cycles_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        instr_done |-> instr_cycles != '0);

endmodule

bind byte_fetch_seq bfs_checker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_bfs_chk (
    .clk           (clk),
    .rst           (rst),
    .compat_mode   (compat_mode),
    .ext_code      (ext_code),
    .code_addr     (code_addr),
    .code_rd       (code_rd),
    .branch_target (branch_target),
    .instr_done    (instr_done),
    .instr_cycles  (instr_cycles),
    .xdata_busy    (xdata_busy),
    .tgt_load      (tgt_load),
    .discard       (discard)
);

// File: tb/byte_fetch_seq_bench.sv
`timescale 1ns/1ps
module byte_fetch_seq_bench;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 8;
    localparam int NPROG  = 36;
    localparam int NDIR   = 11;
    localparam int SEG_LIMIT = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              compat_mode = 1'b0;
    logic              ext_code = 1'b0;
    logic [ADDR_W-1:0] code_addr;
    logic              code_rd;
    logic [DATA_W-1:0] code_data;
    logic [ADDR_W-1:0] branch_target;
    logic [DATA_W-1:0] opcode, operand1, operand2;
    logic              instr_done;
    logic [CNT_W-1:0]  instr_cycles;
    logic              xdata_busy;

    logic [7:0] mem [0:255];
    int e_addr [0:NPROG];
    int e_op   [0:NPROG];
    int e_o1   [0:NPROG];
    int e_o2   [0:NPROG];

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign code_data     = mem[code_addr[7:0]];
    assign branch_target = {8'h00, operand1};

    byte_fetch_seq u_byte_fetch_seq (
        .clk           (clk),
        .rst           (rst),
        .compat_mode   (compat_mode),
        .ext_code      (ext_code),
        .code_addr     (code_addr),
        .code_rd       (code_rd),
        .code_data     (code_data),
        .dec_len       (code_data[1:0]),
        .dec_class     (code_data[4:2]),
        .dec_extra     (code_data[7:5]),
        .branch_target (branch_target),
        .opcode        (opcode),
        .operand1      (operand1),
        .operand2      (operand2),
        .instr_done    (instr_done),
        .instr_cycles  (instr_cycles),
        .xdata_busy    (xdata_busy)
    );

    // Opcode layout used by the bench decoder: [1:0] length, [4:2] class, [7:5] extra
    function automatic int b_len(input int op);
        int l = op & 3;
        return (l == 0) ? 1 : l;
    endfunction

    function automatic int b_cls(input int op);
        int c = (op >> 2) & 7;
        return (c > 4) ? 0 : c;
    endfunction

    function automatic int b_extra(input int op);
        case (b_cls(op))
            1, 2:    return 1;
            3:       return 3;
            4:       return (op >> 5) & 7;
            default: return 0;
        endcase
    endfunction

    function automatic int b_mc(input int op);
        case (b_cls(op))
            0:       return (b_len(op) == 3) ? 2 : 1;
            4:       return 1 + ((op >> 5) & 7);
            default: return 2;
        endcase
    endfunction

    function automatic int b_fw(input bit cm, input bit ex);
        return (!cm && ex) ? 3 : 1;
    endfunction

    function automatic int b_total(input int op, input bit cm, input bit ex);
        if (cm) return 12 * b_mc(op);
        return b_fw(cm, ex) * b_len(op) + b_extra(op);
    endfunction

    function automatic int b_reads(input int op, input bit cm, input bit ex);
        return b_fw(cm, ex) * b_len(op) + ((b_cls(op) == 1) ? 1 : 0);
    endfunction

    function automatic int b_busy(input int op, input bit cm);
        if (b_cls(op) != 3) return 0;
        return cm ? (12 * b_mc(op) - b_len(op)) : 3;
    endfunction

    function automatic string b_tag(input int op, input bit cm, input bit ex);
        if (cm) return "R8";
        if (ex) return "R7";
        if ((op & 3) == 0 || ((op >> 2) & 7) > 4) return "R10";
        case (b_cls(op))
            1:       return "R4";
            2, 4:    return "R5";
            3:       return "R6";
            default: return "R2";
        endcase
    endfunction

    function automatic int dir_op(input int i);
        case (i)
            0:  return 8'h01;  // plain 1 byte
            1:  return 8'h02;  // plain 2 bytes
            2:  return 8'h09;  // pointer increment
            3:  return 8'h0D;  // external move
            4:  return 8'h06;  // branch 2 bytes
            5:  return 8'h03;  // plain 3 bytes
            6:  return 8'h11;  // multi, extra 0
            7:  return 8'hF2;  // multi, extra 7, 2 bytes
            8:  return 8'hBA;  // reserved class 6
            9:  return 8'h00;  // zero length
            default: return 8'h07; // branch 3 bytes
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build_program();
        int a = 0;
        for (int j = 0; j < 256; j++) mem[j] = 8'h01;
        for (int i = 0; i < NPROG; i++) begin
            int op;
            int l;
            int nxt;
            if (i < NDIR)            op = dir_op(i);
            else if (i == NPROG - 1) op = 8'h01;
            else                     op = int'($urandom & 32'hFF);
            if (b_cls(op) == 1 && b_len(op) < 2) op = (op & 8'hFC) | 2;
            l = b_len(op);
            nxt = a + l;
            e_o1[i] = int'($urandom & 32'hFF);
            e_o2[i] = int'($urandom & 32'hFF);
            if (b_cls(op) == 1) begin
                int gap = int'($urandom % 4);
                for (int g = 0; g < gap; g++) mem[nxt + g] = 8'($urandom);
                nxt = nxt + gap;
                e_o1[i] = nxt;
            end
            mem[a] = 8'(op);
            if (l > 1) mem[a + 1] = 8'(e_o1[i]);
            if (l > 2) mem[a + 2] = 8'(e_o2[i]);
            e_addr[i] = a;
            e_op[i]   = op;
            a = nxt;
        end
        e_addr[NPROG] = a;
    endtask

    task automatic run_segment(input bit cm, input bit ex);
        int k = 0;
        int cyc = 0;
        int since = 0;
        int rdc = 0;
        int bc = 0;
        rst = 1'b1;
        compat_mode = cm;
        ext_code = ex;
        build_program();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(code_addr == 0, "R1", "address after reset", int'(code_addr), 0);
        chk(code_rd == 1'b1, "R1", "read strobe after reset", int'(code_rd), 1);
        chk(instr_done == 1'b0, "R1", "done after reset", int'(instr_done), 0);
        chk(instr_cycles == 0, "R1", "cycle count after reset", int'(instr_cycles), 0);
        while (k < NPROG - 1 && cyc < SEG_LIMIT) begin
            @(negedge clk);
            cyc++;
            since++;
            rdc += int'(code_rd);
            bc  += int'(xdata_busy);
            if (instr_done) begin
                string t = b_tag(e_op[k], cm, ex);
                int    op = e_op[k];
                chk(int'(instr_cycles) == b_total(op, cm, ex), t, "instruction clocks",
                    int'(instr_cycles), b_total(op, cm, ex));
                chk(int'(code_addr) == e_addr[k+1], (b_cls(op) == 1) ? "R4" : "R3",
                    "next opcode address", int'(code_addr), e_addr[k+1]);
                chk(int'(opcode) == op, "R2", "captured opcode", int'(opcode), op);
                if (b_len(op) > 1)
                    chk(int'(operand1) == e_o1[k], "R2", "captured operand1",
                        int'(operand1), e_o1[k]);
                if (b_len(op) > 2)
                    chk(int'(operand2) == e_o2[k], "R2", "captured operand2",
                        int'(operand2), e_o2[k]);
                chk(bc == b_busy(op, cm), "R6", "stall clocks", bc, b_busy(op, cm));
                if (k > 0) begin
                    chk(rdc == b_reads(op, cm, ex), t, "code reads", rdc, b_reads(op, cm, ex));
                    chk(since == int'(instr_cycles), "R9", "measured interval",
                        int'(instr_cycles), since);
                end
                k++;
                since = 0;
                rdc = 0;
                bc = 0;
            end
        end
        if (cyc >= SEG_LIMIT)
            chk(1'b0, "R3", "watchdog expired", cyc, SEG_LIMIT);
    endtask

    initial begin
        int seed_sink;
        seed_sink = int'($urandom(32'd20240611));
        for (int s = 0; s < 8; s++) begin
            run_segment(s[1], s[0]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule